// File: doc/BRIEF.md
# Programmable-Rule Ring Cellular Automaton

This block is a ring of single-bit cells that advance in lockstep. On every step each cell looks at its own bit and the bits of the cells on either side of it. Those three bits select one bit from an 8-entry rule that belongs to that cell, and the selected bit becomes the cell's new value. Each cell has its own rule, so the ring can run one uniform automaton or a mix of automata.

A host loads the starting pattern and the rules through a write port while the ring is idle. Rules can go to a single cell or to every cell at once. The host then pulses or holds the step input and watches the exposed state vector.

A flag rises whenever every cell holds the same value, and a second output tells which value that is. The host uses the flag to detect that a run has reached the synchronised condition from a scattered starting pattern.

Top module: `ca_ring`

## Requirements
- R1: A synchronous reset clears every cell and every rule to zero. After reset the flag `sync` is 1 and `sync_val` is 0.
- R2: In a clock cycle with `step` high, each cell n takes bit `idx` of its own rule, where `idx` = {left, self, right}: the left neighbour (cell n-1) is bit 2, the cell itself is bit 1 and the right neighbour (cell n+1) is bit 0. All cells update on the same edge, and the result is visible after that edge.
- R3: The ring wraps around. Cell 0's left neighbour is cell N_CELLS-1, and cell N_CELLS-1's right neighbour is cell 0.
- R4: In a cycle with `step` low and `state_we` low, the state vector keeps its value.
- R5: With `step` low, `rule_we` high and `rule_bcast` low, `rule_in` replaces the rule of cell `rule_addr` only. Every other cell's rule is unchanged.
- R6: With `step` low, `rule_we` high and `rule_bcast` high, `rule_in` replaces the rule of every cell.
- R7: With `step` low and `state_we` high, the state vector becomes `state_in` after the edge.
- R8: While `step` is high, writes to the state and to the rules are ignored. That cycle's step uses the rules that were already stored.
- R9: `sync` is 1 exactly when every cell is 0 or every cell is 1. While `sync` is 1, `sync_val` equals that common value.
- R10: A single-cell rule write whose `rule_addr` is N_CELLS or higher changes no rule.
- R11: A state write and a rule write in the same idle cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance all cells on this edge |
| state_we | input | 1 | Load `state_in` into the cells (only while `step` is low) |
| state_in | input | N_CELLS | Pattern to load |
| rule_we | input | 1 | Write `rule_in` to one or all cells (only while `step` is low) |
| rule_bcast | input | 1 | 1: write to every cell; 0: write to cell `rule_addr` |
| rule_addr | input | ADDR_W | Target cell of a single-cell rule write |
| rule_in | input | 8 | Rule value; bit i is the next state for neighbourhood i |
| cells | output | N_CELLS | Current state of the ring, bit n = cell n |
| sync | output | 1 | All cells hold the same value |
| sync_val | output | 1 | The common value while `sync` is 1 |

## Verification
The bench sweeps all 256 uniform rules against every starting pattern of a six-cell ring. Swapped left and right neighbours in the index, or a ring that does not wrap at its ends, produces a mismatch on the edge cells almost at once.

A set of distinct per-cell rules exposes a design that applies one cell's rule everywhere or decodes `rule_addr` wrongly. Out-of-range addresses catch a design that aliases them onto real cells.

Writes issued during a step catch a design that lets the loader override or corrupt the update. The sweep also crosses the all-zero and all-one patterns, so a flag that tests only one polarity shows up.

// File: rtl/ca_pkg.sv
package ca_pkg;
    localparam int NBR_W  = 3;
    localparam int RULE_W = 1 << NBR_W;
    typedef logic [RULE_W-1:0] rule_t;
    typedef logic [NBR_W-1:0]  nbr_t;
endpackage

// File: rtl/ca_cell.sv
module ca_cell
    import ca_pkg::*;
(
    input  logic  left_i,
    input  logic  self_i,
    input  logic  right_i,
    input  rule_t rule_i,
    output logic  next_o
);
    nbr_t idx;
    assign idx    = {left_i, self_i, right_i};
    assign next_o = rule_i[idx];
endmodule

// File: rtl/ca_uniform.sv
module ca_uniform #(
    parameter int WIDTH = 56
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             all_zero_o,
    output logic             all_one_o
);
    assign all_zero_o = ~|vec_i;
    assign all_one_o  = &vec_i;
endmodule

// File: rtl/ca_ring.sv
module ca_ring
    import ca_pkg::*;
#(
    parameter int N_CELLS = 56,
    localparam int ADDR_W = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic               state_we,
    input  logic [N_CELLS-1:0] state_in,
    input  logic               rule_we,
    input  logic               rule_bcast,
    input  logic [ADDR_W-1:0]  rule_addr,
    input  logic [RULE_W-1:0]  rule_in,
    output logic [N_CELLS-1:0] cells,
    output logic               sync,
    output logic               sync_val
);
    typedef struct packed {
        logic [N_CELLS-1:0]  cells;
        rule_t [N_CELLS-1:0] rules;
    } ring_regs_t;

    ring_regs_t regs_d, regs_q;
    logic [N_CELLS-1:0] stepped;
    logic all_zero, all_one;

    // neighbourhood lookup for each cell, ends wrap around
    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        localparam int LEFT  = (g + N_CELLS - 1) % N_CELLS;
        localparam int RIGHT = (g + 1) % N_CELLS;
        ca_cell u_cell (
            .left_i (regs_q.cells[LEFT]),
            .self_i (regs_q.cells[g]),
            .right_i(regs_q.cells[RIGHT]),
            .rule_i (regs_q.rules[g]),
            .next_o (stepped[g])
        );
    end

    ca_uniform #(.WIDTH(N_CELLS)) u_uniform (
        .vec_i     (regs_q.cells),
        .all_zero_o(all_zero),
        .all_one_o (all_one)
    );

    always_comb begin
        regs_d = regs_q;
        if (step) begin
            regs_d.cells = stepped;
        end else begin
            if (state_we) regs_d.cells = state_in;
            if (rule_we) begin
                for (int i = 0; i < N_CELLS; i++) begin
                    if (rule_bcast || (rule_addr == ADDR_W'(i)))
                        regs_d.rules[i] = rule_in;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign cells    = regs_q.cells;
    assign sync     = all_zero | all_one;
    assign sync_val = all_one;
endmodule

// File: rtl/ca_ring_chk.sv
module ca_ring_chk #(
    parameter int N_CELLS = 56
) (
    input logic               clk,
    input logic               rst,
    input logic               step,
    input logic               state_we,
    input logic [N_CELLS-1:0] state_in,
    input logic [N_CELLS-1:0] cells,
    input logic               sync,
    input logic               sync_val
);
    localparam logic [N_CELLS-1:0] ONES = {N_CELLS{1'b1}};
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (cells == '0 && sync && !sync_val));
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !state_we) |=> $stable(cells));
    a_r7_state_load: assert property (@(posedge clk) disable iff (rst)
        (!step && state_we) |=> (cells == $past(state_in)));
    a_r9_sync_set: assert property (@(posedge clk) disable iff (rst)
        sync |-> (cells == '0 || cells == ONES));
    a_r9_sync_clr: assert property (@(posedge clk) disable iff (rst)
        !sync |-> (cells != '0 && cells != ONES));
    a_r9_sync_value: assert property (@(posedge clk) disable iff (rst)
        sync |-> ($countones(cells) == (sync_val ? N_CELLS : 0)));
endmodule

bind ca_ring ca_ring_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .state_we(state_we),
    .state_in(state_in),
    .cells   (cells),
    .sync    (sync),
    .sync_val(sync_val)
);

// File: tb/ca_ring_bench.sv
module ca_ring_bench;
    localparam int N  = 6;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step = 1'b0, state_we = 1'b0, rule_we = 1'b0, rule_bcast = 1'b0;
    logic [N-1:0] state_in = '0;
    logic [AW-1:0] rule_addr = '0;
    logic [7:0] rule_in = '0;
    logic [N-1:0] cells;
    logic sync, sync_val;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] mr [N];
    logic [N-1:0] ms;

    always #4 clk = ~clk;

    ca_ring #(.N_CELLS(N)) u_ca_ring (
        .clk(clk), .rst(rst), .step(step), .state_we(state_we),
        .state_in(state_in), .rule_we(rule_we), .rule_bcast(rule_bcast),
        .rule_addr(rule_addr), .rule_in(rule_in), .cells(cells),
        .sync(sync), .sync_val(sync_val)
    );

    function automatic logic [N-1:0] model_next(input logic [N-1:0] s);
        logic [N-1:0] r;
        for (int n = 0; n < N; n++) begin
            logic [2:0] idx;
            idx  = {s[(n + N - 1) % N], s[n], s[(n + 1) % N]};
            r[n] = mr[n][idx];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_sync(input string tag);
        logic es, ev;
        es = (ms == '0) || (ms == {N{1'b1}});
        ev = ms[0];
        check(tag, N'({sync, sync & sync_val}), N'({es, es & ev}));
    endtask

    task automatic put_rule(input int addr, input bit bc, input logic [7:0] v);
        @(negedge clk);
        rule_we = 1; rule_bcast = bc; rule_addr = AW'(addr); rule_in = v;
        @(negedge clk);
        rule_we = 0; rule_bcast = 0;
        for (int i = 0; i < N; i++) if (bc || i == addr) mr[i] = v;
    endtask

    task automatic put_state(input logic [N-1:0] s);
        @(negedge clk);
        state_we = 1; state_in = s;
        @(negedge clk);
        state_we = 0;
        ms = s;
    endtask

    task automatic do_step(input string tag);
        @(negedge clk);
        step = 1;
        @(negedge clk);
        step = 0;
        ms = model_next(ms);
        check(tag, cells, ms);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mr[i] = '0;
        ms = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state, then rules are zero: all-ones steps to zero
        check("R1 cells", cells, '0);
        check_sync("R1 sync");
        put_state('1);
        check_sync("R9 all ones");
        do_step("R1 rules cleared");

        // R2 R3 R6 R7 R9: every uniform rule against every pattern
        for (int r = 0; r < 256; r++) begin
            put_rule(0, 1, 8'(r));
            for (int s = 0; s < (1 << N); s++) begin
                put_state(N'(s));
                check("R7 load", cells, ms);
                check_sync("R9 flag");
                do_step("R2 R3 R6 uniform step");
            end
        end

        // R5: distinct rule per cell, many steps
        for (int i = 0; i < N; i++) put_rule(i, 0, 8'(i * 37 + 11));
        put_state(6'b100101);
        for (int k = 0; k < 24; k++) do_step("R5 per-cell step");

        // R10: out-of-range single writes ignored
        put_rule(N, 0, 8'hA5);
        put_rule(N + 1, 0, 8'h3C);
        put_state(6'b011010);
        for (int k = 0; k < 8; k++) do_step("R10 addr ignored");

        // R4: idle cycles hold state
        put_state(6'b110001);
        repeat (5) @(negedge clk);
        check("R4 hold", cells, ms);

        // R8: writes during step are dropped
        @(negedge clk);
        step = 1; state_we = 1; state_in = 6'b000111;
        rule_we = 1; rule_bcast = 1; rule_in = 8'hFF;
        @(negedge clk);
        step = 0; state_we = 0; rule_we = 0; rule_bcast = 0;
        ms = model_next(ms);
        check("R8 state write dropped", cells, ms);
        for (int k = 0; k < 6; k++) do_step("R8 rule write dropped");

        // R11: simultaneous state and rule write
        @(negedge clk);
        state_we = 1; state_in = 6'b001011;
        rule_we = 1; rule_bcast = 0; rule_addr = 3'd2; rule_in = 8'h96;
        @(negedge clk);
        state_we = 0; rule_we = 0;
        ms = 6'b001011; mr[2] = 8'h96;
        check("R11 state", cells, ms);
        for (int k = 0; k < 6; k++) do_step("R11 rule");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule